// File: doc/BRIEF.md
# Port Glitch Filter Bank

This block cleans up the eight input pins of one port before other on-chip logic sees them. Each raw pin first passes through a two-flop synchronizer. A pin may then be filtered. Filtering applies when the pin's enable bit is set and the pin's digital-mode qualifier is high. A filtered pin takes a new level only after that level has persisted for a programmed number of filter clock ticks. Short pulses in either direction are absorbed. A pin that is not filtered shows its synchronized level directly.

Two registers configure the block through a small write port. One holds the per-pin enables. The other holds the controls shared by every pin: the filter factor (the tick count) and the filter clock select. Both filter clocks arrive as single-cycle tick enables on the system clock. One tick stands for the bus clock and the other for a low-power oscillator. The `stop_mode` input removes the bus tick, so only the low-power tick keeps filtering alive during stop. The shared controls may change only while no pin is enabled. A control write made at any other time is dropped and raises `cfg_err`.

Each pin runs a small state machine with three states:
- `ST_PASS`: the filter is off and the output follows the synchronizer.
- `ST_HOLD`: the filter is on, the input agrees with the output, and the counter is clear.
- `ST_COUNT`: the input disagrees with the output, and ticks are being counted.

The transitions are:
- enable: `ST_PASS` to `ST_HOLD`, loading the output from the input.
- disable: any filtering state to `ST_PASS`.
- start: `ST_HOLD` to `ST_COUNT`, on a tick while the input differs and the count is still short of the factor.
- count: `ST_COUNT` to `ST_COUNT`, on a further tick that is still short.
- accept: to `ST_HOLD`, on the tick that reaches the factor; the output takes the new level.
- revert: `ST_COUNT` to `ST_HOLD` when the input returns to the output level; the counter clears.

Top module: `glf_bank`

## Requirements
- R1: After reset, `filt_out` is 0 and `cfg_err` is 0. All enables are clear, the filter factor is 0 and the bus tick is selected.
- R2: A pin whose enable bit is clear, or whose `dig_mode` bit is low, drives `filt_out` with its `pin_in` level delayed by exactly two clock edges.
- R3: In a control write, `wr_data[4:0]` is the filter factor and `wr_data[5]` is the clock select. A select of 1 uses `lp_tick` and a select of 0 uses `bus_tick`.
- R4: For a filtered pin with a nonzero factor F, consider an excursion of the synchronized input away from the output. If it spans fewer than F filter ticks, it never reaches `filt_out`. If it spans F ticks, the output takes the new level right after the edge of the F-th tick. This holds in both the up-down-up and the down-up-down direction.
- R5: With a factor of 0, a filtered pin passes its input with the same two-edge latency as an unfiltered pin.
- R6: A write with `wr_addr`=0 loads the enable register from `wr_data[7:0]`. A write with `wr_addr`=1 loads the control register, but only while the enable register is all zeros. When the enable register is not all zeros, that write is ignored and `cfg_err` becomes 1. An accepted control write clears `cfg_err`.
- R7: While `stop_mode` is 1, the bus tick is suppressed. A filtered pin on the bus-clock select then cannot change level. A pin on the low-power select keeps filtering.
- R8: Enabling a pin's filter loads its output from the current synchronized input, so the enabling itself makes no edge on `filt_out`.
- R9: The tick count restarts whenever the synchronized input returns to the output level. Two short excursions separated by a one-cycle return are therefore both rejected.
- R10: One factor and one clock select govern every filtered pin at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Raw pin levels |
| dig_mode | input | 8 | Per-pin digital-mode qualifier |
| bus_tick | input | 1 | Bus-clock filter tick enable |
| lp_tick | input | 1 | Low-power oscillator filter tick enable |
| stop_mode | input | 1 | Stop mode; suppresses the bus tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the enable register, 1 selects the control register |
| wr_data | input | 8 | Write data |
| filt_out | output | 8 | Filtered pin levels |
| cfg_err | output | 1 | Set when a control write is ignored |

## Verification
The hardest case to reach is a rejected control write whose effect must be proven absent. The proof uses only the outputs, since the stored factor and select cannot be read back. The stimulus holds a nonzero enable while writing a smaller factor and the bus select. It then sends a pulse that the attempted settings would pass but the kept low-power settings must absorb. Stop mode comes next: a held level change must stay off the output while the bus tick is removed. Ticks that resume after stop, or a switch to the low-power tick, must then let that change through.

// File: rtl/glf_pkg.sv
package glf_pkg;
    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_COUNT = 2'd2
    } pin_state_e;

    localparam logic ADDR_ENABLE  = 1'b0;
    localparam logic ADDR_CONTROL = 1'b1;
endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= d_in;
            safe_q <= meta_q;
        end
    end

    assign d_out = safe_q;
endmodule

// File: rtl/glf_regs.sv
module glf_regs
    import glf_pkg::*;
#(
    parameter int PINS = 8,
    parameter int FFW  = 5,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            bus_tick,
    input  logic            lp_tick,
    input  logic            stop_mode,
    output logic [PINS-1:0] en_q,
    output logic [FFW-1:0]  ff_q,
    output logic            sel_q,
    output logic            err_q,
    output logic            tick
);
    logic ctl_wr;
    logic ctl_locked;

    assign ctl_wr     = wr_en && (wr_addr == ADDR_CONTROL);
    assign ctl_locked = |en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            ff_q  <= '0;
            sel_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (wr_en && (wr_addr == ADDR_ENABLE)) begin
                en_q <= wr_data[PINS-1:0];
            end
            if (ctl_wr) begin
                if (ctl_locked) begin
                    err_q <= 1'b1;
                end else begin
                    ff_q  <= wr_data[FFW-1:0];
                    sel_q <= wr_data[FFW];
                    err_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        if (sel_q) begin
            tick = lp_tick;
        end else begin
            tick = bus_tick && !stop_mode;
        end
    end
endmodule

// File: rtl/glf_pin.sv
module glf_pin
    import glf_pkg::*;
#(
    parameter int FFW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic [FFW-1:0] ff,
    input  logic           tick,
    input  logic           sin,
    output logic           fout
);
    localparam int CW = FFW + 1;

    pin_state_e     st_q, st_d;
    logic           out_q, out_d;
    logic [FFW-1:0] cnt_q, cnt_d;
    logic [CW-1:0]  cnt_inc;
    logic           ff_zero;

    assign ff_zero = (ff == '0);
    assign cnt_inc = {1'b0, cnt_q} + CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_PASS;
            out_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        out_d = out_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_PASS: begin
                out_d = sin;
                cnt_d = '0;
                if (active) begin
                    st_d = ST_HOLD;
                end
            end
            ST_HOLD, ST_COUNT: begin
                if (!active) begin
                    st_d  = ST_PASS;
                    cnt_d = '0;
                    out_d = sin;
                end else if (ff_zero) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                    out_d = sin;
                end else if (sin == out_q) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_inc >= {1'b0, ff}) begin
                        st_d  = ST_HOLD;
                        cnt_d = '0;
                        out_d = sin;
                    end else begin
                        st_d  = ST_COUNT;
                        cnt_d = cnt_inc[FFW-1:0];
                    end
                end
            end
            default: begin
                st_d  = ST_PASS;
                cnt_d = '0;
                out_d = sin;
            end
        endcase
    end

    always_comb begin
        if ((st_q == ST_PASS) || ff_zero) begin
            fout = sin;
        end else begin
            fout = out_q;
        end
    end
endmodule

// File: rtl/glf_bank.sv
module glf_bank #(
    parameter  int PINS = 8,
    parameter  int FFW  = 5,
    localparam int DW   = (PINS > FFW + 1) ? PINS : FFW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] dig_mode,
    input  logic            bus_tick,
    input  logic            lp_tick,
    input  logic            stop_mode,
    input  logic            wr_en,
    input  logic            wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [PINS-1:0] filt_out,
    output logic            cfg_err
);
    logic [PINS-1:0] sync_vec;
    logic [PINS-1:0] en_vec;
    logic [FFW-1:0]  ff_val;
    logic            sel_val;
    logic            flt_tick;

    glf_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in),
        .d_out (sync_vec)
    );

    glf_regs #(.PINS(PINS), .FFW(FFW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bus_tick  (bus_tick),
        .lp_tick   (lp_tick),
        .stop_mode (stop_mode),
        .en_q      (en_vec),
        .ff_q      (ff_val),
        .sel_q     (sel_val),
        .err_q     (cfg_err),
        .tick      (flt_tick)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        glf_pin #(.FFW(FFW)) u_pin (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (en_vec[i] & dig_mode[i]),
            .ff     (ff_val),
            .tick   (flt_tick),
            .sin    (sync_vec[i]),
            .fout   (filt_out[i])
        );
    end
endmodule

// File: rtl/glf_bank_chk.sv
module glf_bank_chk #(
    parameter int PINS = 8,
    parameter int FFW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PINS-1:0] pin_in,
    input logic [PINS-1:0] dig_mode,
    input logic            stop_mode,
    input logic            wr_en,
    input logic            wr_addr,
    input logic [PINS-1:0] filt_out,
    input logic            cfg_err,
    input logic [PINS-1:0] en_vec,
    input logic [FFW-1:0]  ff_val,
    input logic            sel_val,
    input logic            flt_tick
);
    logic [1:0]      warm;
    logic [PINS-1:0] act;

    assign act = en_vec & dig_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm <= 2'd0;
        end else if (warm != 2'd3) begin
            warm <= warm + 2'd1;
        end
    end

    // R2
    pass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (((filt_out ^ $past(pin_in, 2)) & $past(~act)) == '0));

    // R4
    tick_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((warm != 2'd0) && (ff_val != '0) && ($past(ff_val) != '0) && !$past(flt_tick))
        |-> (((filt_out ^ $past(filt_out)) & act & $past(act)) == '0));

    // R6
    locked_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr && (en_vec != '0)) |=> cfg_err);

    // R6
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec != '0) |=> ($stable(ff_val) && $stable(sel_val)));

    // R7
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && !sel_val && (ff_val != '0) && (warm != 2'd0))
        |=> (((filt_out ^ $past(filt_out)) & act & $past(act)) == '0));
endmodule

bind glf_bank glf_bank_chk #(.PINS(PINS), .FFW(FFW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_in    (pin_in),
    .dig_mode  (dig_mode),
    .stop_mode (stop_mode),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .filt_out  (filt_out),
    .cfg_err   (cfg_err),
    .en_vec    (en_vec),
    .ff_val    (ff_val),
    .sel_val   (sel_val),
    .flt_tick  (flt_tick)
);

// File: tb/tb_glf_bank.sv
module tb_glf_bank;
    localparam int P = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] pin_in = '0;
    logic [P-1:0] dig_mode = '1;
    logic         bus_tick = 1'b1;
    logic         lp_tick = 1'b0;
    logic         stop_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_addr = 1'b0;
    logic [7:0]   wr_data = '0;
    logic [P-1:0] filt_out;
    logic         cfg_err;

    glf_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .dig_mode  (dig_mode),
        .bus_tick  (bus_tick),
        .lp_tick   (lp_tick),
        .stop_mode (stop_mode),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .filt_out  (filt_out),
        .cfg_err   (cfg_err)
    );

    always #2.5 clk = ~clk;

    logic [1:0] lp_div = '0;
    always @(posedge clk) begin
        lp_div  <= lp_div + 2'd1;
        lp_tick <= (lp_div == 2'd3);
    end

    typedef enum int {K_VAL, K_TOG, K_ERR} kind_e;
    typedef struct {
        kind_e kind;
        string req;
        int    pin;
        int    exp;
    } item_t;

    item_t        sbq[$];
    int           errors = 0;
    int           checks = 0;
    int           tog[P];
    int           exp_tog[P];
    logic [P-1:0] prev_out = '0;
    bit           done = 1'b0;

    always @(negedge clk) begin
        for (int i = 0; i < P; i++) begin
            if (rst_n && (filt_out[i] !== prev_out[i])) tog[i]++;
        end
        prev_out = filt_out;
        while (sbq.size() > 0) begin
            item_t it;
            int    act;
            it = sbq.pop_front();
            case (it.kind)
                K_VAL:   act = int'(filt_out);
                K_TOG:   act = tog[it.pin];
                default: act = int'(cfg_err);
            endcase
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d pin=%0d actual=%0d expected=%0d",
                         it.req, it.kind, it.pin, act, it.exp);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(kind_e k, string r, int pin, int e);
        item_t it;
        it.kind = k; it.req = r; it.pin = pin; it.exp = e;
        sbq.push_back(it);
    endtask

    task automatic expect_tog_all(string r);
        for (int i = 0; i < P; i++) push(K_TOG, r, i, exp_tog[i]);
    endtask

    task automatic wr(logic a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse(int pin, int len);
        pin_in[pin] = ~pin_in[pin];
        step(len);
        pin_in[pin] = ~pin_in[pin];
    endtask

    initial begin
        for (int i = 0; i < P; i++) begin tog[i] = 0; exp_tog[i] = 0; end
        step(3);
        rst_n = 1'b1;
        step(1);
        push(K_VAL, "R1", 0, 0);
        push(K_ERR, "R1", 0, 0);

        // R2 pass-through with filters off, two-edge latency
        pin_in = 8'hA5;
        step(1);
        push(K_VAL, "R2", 0, 0);
        step(1);
        push(K_VAL, "R2", 0, 'hA5);
        exp_tog[0]++; exp_tog[2]++; exp_tog[5]++; exp_tog[7]++;
        step(2);

        // R3 factor 4 on bus tick, then R8 enable without edge
        wr(1'b1, 8'h04);
        push(K_ERR, "R3", 0, 0);
        wr(1'b0, 8'hFF);
        step(4);
        push(K_VAL, "R8", 0, 'hA5);
        expect_tog_all("R8");

        // R4 up-down-up on pin1: 3 cycles rejected, 4 accepted
        pulse(1, 3);
        step(10);
        push(K_TOG, "R4", 1, exp_tog[1]);
        pulse(1, 4);
        step(12);
        exp_tog[1] += 2;
        push(K_TOG, "R4", 1, exp_tog[1]);
        // R4 down-up-down on pin0 (high): 3-cycle low rejected
        pulse(0, 3);
        step(10);
        push(K_TOG, "R4", 0, exp_tog[0]);
        push(K_VAL, "R4", 0, 'hA5);
        // R10: same factor on pin7
        pulse(7, 3);
        step(10);
        push(K_TOG, "R10", 7, exp_tog[7]);

        // R9 counter restarts: 3 high, 1 low, 3 high
        pin_in[1] = 1'b1; step(3);
        pin_in[1] = 1'b0; step(1);
        pin_in[1] = 1'b1; step(3);
        pin_in[1] = 1'b0;
        step(10);
        push(K_TOG, "R9", 1, exp_tog[1]);

        // R2 non-digital pin bypasses filter
        dig_mode[2] = 1'b0;
        step(2);
        pulse(2, 1);
        step(6);
        exp_tog[2] += 2;
        push(K_TOG, "R2", 2, exp_tog[2]);
        dig_mode[2] = 1'b1;
        step(3);

        // R7 stop mode freezes bus-tick filtering
        stop_mode = 1'b1;
        pin_in[3] = 1'b1;
        step(20);
        push(K_TOG, "R7", 3, exp_tog[3]);
        stop_mode = 1'b0;
        step(8);
        exp_tog[3]++;
        push(K_VAL, "R7", 0, 'hAD);

        // R6 switch to low-power tick, factor 2
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h22);
        push(K_ERR, "R6", 0, 0);
        wr(1'b0, 8'hFF);
        step(4);
        // R6 locked write: ff=1 bus tick must not take effect
        wr(1'b1, 8'h01);
        push(K_ERR, "R6", 0, 1);
        pulse(4, 4);
        step(16);
        push(K_TOG, "R6", 4, exp_tog[4]);
        // R3/R7 low-power tick keeps filtering in stop
        stop_mode = 1'b1;
        pulse(4, 4);
        step(16);
        push(K_TOG, "R3", 4, exp_tog[4]);
        pulse(4, 16);
        step(20);
        exp_tog[4] += 2;
        push(K_TOG, "R7", 4, exp_tog[4]);
        stop_mode = 1'b0;

        // R5 factor zero: two-edge latency while filtering
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h00);
        push(K_ERR, "R6", 0, 0);
        wr(1'b0, 8'hFF);
        step(3);
        pin_in[6] = 1'b1;
        step(1);
        push(K_VAL, "R5", 0, 'hAD);
        step(1);
        push(K_VAL, "R5", 0, 'hED);
        exp_tog[6]++;
        pulse(5, 1);
        step(6);
        exp_tog[5] += 2;
        push(K_TOG, "R5", 5, exp_tog[5]);
        expect_tog_all("R10");
        step(2);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule